// File: doc/BRIEF.md
# Miss Reissue Timeout Controller

This block follows a single outstanding cache miss from the moment its request goes out until enough tokens have been gathered to satisfy it. A read is satisfied by one token and a write needs every token of the block. No ordering is assumed on the interconnect, so a race simply shows up as a miss that takes too long. The controller times each attempt against a limit derived from a running average of recent miss latencies. When the limit passes without completion, it sends the request again.

After a fixed number of normal attempts have timed out, the controller stops sending normal requests. It escalates to a persistent request, which is timed with a longer window and is re-sent each time that window expires. On completion, the measured latency is folded into the running average, and the timer and the attempt count start fresh for the next miss.

Top module: `miss_reissue_ctrl`

## Requirements
- R1: After reset, `busy`, `req_issue`, `persist_issue` and `miss_done` are all 0.
- R2: A `miss_start` sampled while idle makes `busy` 1 from the next cycle. In that same next cycle, `req_issue` is high for exactly one cycle. The value of `miss_write` captured at that edge selects the request type (1 = write, 0 = read).
- R3: While busy, the tokens seen so far plus `tok_in` form a running sum. `miss_done` is 1 in the same cycle that this sum reaches 1 for a read, or TOKENS for a write. `busy` is 0 from the next cycle.
- R4: Attempt timing is as follows.
  - The attempt timer is 0 in the first busy cycle of each attempt and then counts busy cycles.
  - The normal limit is max(2·avg, MIN_TIMEOUT), capped at 2^TIMER_W−1.
  - In an unsatisfied cycle where the timer is at or above the limit, an attempt expires.
  - If fewer than RETRY_LIMIT normal requests have been sent, a new `req_issue` pulse follows in the next cycle. Consecutive issue pulses are therefore limit+1 cycles apart.
- R5: The expiry that follows the RETRY_LIMIT-th normal request raises `persist_issue` for one cycle instead of `req_issue`. From then on, the limit is avg·2^PERSIST_SHIFT, with the same floor and cap as in R4.
- R6: Each expiry while in persistent mode raises `persist_issue` again. No further `req_issue` pulse is produced for that miss.
- R7: The latency of a miss is the number of busy cycles before its completing cycle. On completion, the running average becomes avg + floor((latency − avg) / 2^AVG_SHIFT). Its value after reset is INIT_AVG.
- R8: A `miss_start` while busy is ignored. A nonzero `tok_in` while idle is ignored and does not count toward the next miss.
- R9: The timer and the latency counter saturate at 2^TIMER_W−1 rather than wrapping. Every limit is capped at that value, so a long limit still expires.
- R10: When the satisfying tokens arrive in a cycle where the timer has reached the limit, the miss completes and no request of either kind follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_start | input | 1 | Begin tracking a new miss (taken only when idle) |
| miss_write | input | 1 | Type of the starting miss: 1 write, 0 read |
| tok_in | input | $clog2(TOKENS+1) | Number of tokens arriving this cycle |
| req_issue | output | 1 | One-cycle pulse: send a normal request |
| persist_issue | output | 1 | One-cycle pulse: send a persistent request |
| miss_done | output | 1 | The miss is satisfied in this cycle |
| busy | output | 1 | A miss is being tracked |

## Verification
The bench builds the block with TOKENS=4, TIMER_W=8, INIT_AVG=3 and MIN_TIMEOUT=8, and keeps the default RETRY_LIMIT of 4 and the default shifts. With these values the floor sets the first normal limit. A write with no tokens walks through all four normal attempts and into repeated persistent requests within a few hundred cycles. A stalled miss that saturates the latency counter lifts the average enough that the persistent limit reaches the 255-cycle cap.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

  typedef enum logic [1:0] {
    MRT_IDLE    = 2'd0,
    MRT_NORMAL  = 2'd1,
    MRT_PERSIST = 2'd2
  } mrt_state_e;

  // A read needs one token, a write needs all of them.
  function automatic logic tokens_enough(input logic is_wr, input int have, input int total);
    return is_wr ? (have >= total) : (have >= 1);
  endfunction

  // One step of the shift-weighted running average (arithmetic shift floors).
  function automatic int ema_step(input int avg, input int sample, input int wshift);
    int diff;
    diff = sample - avg;
    return avg + (diff >>> wshift);
  endfunction

  // Timeout window from the average, with a floor and a cap.
  function automatic int window_of(input int avg, input int mshift, input int floor_v, input int cap);
    int v;
    v = avg << mshift;
    if (v < floor_v) v = floor_v;
    if (v > cap) v = cap;
    return v;
  endfunction

endpackage

// File: rtl/mrt_counter.sv
module mrt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  output logic [W-1:0] val
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
    end else if (clr) begin
      val <= '0;
    end else if (run && val != TOP) begin
      val <= val + 1'b1;
    end
  end
endmodule

// File: rtl/mrt_avg.sv
module mrt_avg #(
  parameter int W     = 8,
  parameter int SHIFT = 3,
  parameter int INIT  = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] sample,
  output logic [W-1:0] avg
);
  import mrt_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avg <= W'(INIT);
    end else if (upd) begin
      avg <= W'(ema_step(int'(avg), int'(sample), SHIFT));
    end
  end
endmodule

// File: rtl/miss_reissue_ctrl.sv
module miss_reissue_ctrl #(
  parameter int TOKENS        = 16,
  parameter int TIMER_W       = 12,
  parameter int RETRY_LIMIT   = 4,
  parameter int PERSIST_SHIFT = 3,
  parameter int AVG_SHIFT     = 3,
  parameter int INIT_AVG      = 50,
  parameter int MIN_TIMEOUT   = 8,
  localparam int CNT_W        = $clog2(TOKENS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_start,
  input  logic             miss_write,
  input  logic [CNT_W-1:0] tok_in,
  output logic             req_issue,
  output logic             persist_issue,
  output logic             miss_done,
  output logic             busy
);
  import mrt_pkg::*;

  localparam int TMAX  = (1 << TIMER_W) - 1;
  localparam int ATT_W = $clog2(RETRY_LIMIT + 1);

  mrt_state_e         state;
  logic               wr_q;
  logic [CNT_W-1:0]   gathered;
  logic [ATT_W-1:0]   attempts;
  logic [TIMER_W-1:0] timer_val;
  logic [TIMER_W-1:0] lat_val;
  logic [TIMER_W-1:0] avg_val;
  logic               req_q;
  logic               per_q;

  // Named internal events.
  logic start_ev;
  logic sat_ev;
  logic expire_ev;
  logic retry_ev;
  logic escalate_ev;
  logic repersist_ev;
  int   sum_i;
  int   limit_i;

  always_comb begin
    busy         = (state != MRT_IDLE);
    sum_i        = int'(gathered) + int'(tok_in);
    start_ev     = !busy && miss_start;
    sat_ev       = busy && tokens_enough(wr_q, sum_i, TOKENS);
    limit_i      = window_of(int'(avg_val), (state == MRT_PERSIST) ? PERSIST_SHIFT : 1,
                             MIN_TIMEOUT, TMAX);
    expire_ev    = busy && !sat_ev && (int'(timer_val) >= limit_i);
    retry_ev     = expire_ev && (state == MRT_NORMAL) && (int'(attempts) < RETRY_LIMIT);
    escalate_ev  = expire_ev && (state == MRT_NORMAL) && (int'(attempts) >= RETRY_LIMIT);
    repersist_ev = expire_ev && (state == MRT_PERSIST);
  end

  mrt_counter #(.W(TIMER_W)) u_attempt_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ev || expire_ev || sat_ev),
    .run   (busy),
    .val   (timer_val)
  );

  mrt_counter #(.W(TIMER_W)) u_latency (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_ev || sat_ev),
    .run   (busy),
    .val   (lat_val)
  );

  mrt_avg #(.W(TIMER_W), .SHIFT(AVG_SHIFT), .INIT(INIT_AVG)) u_avg (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd    (sat_ev),
    .sample (lat_val),
    .avg    (avg_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= MRT_IDLE;
      wr_q     <= 1'b0;
      gathered <= '0;
      attempts <= '0;
      req_q    <= 1'b0;
      per_q    <= 1'b0;
    end else begin
      req_q <= start_ev || retry_ev;
      per_q <= escalate_ev || repersist_ev;
      if (start_ev) begin
        state    <= MRT_NORMAL;
        wr_q     <= miss_write;
        gathered <= '0;
        attempts <= ATT_W'(1);
      end else if (sat_ev) begin
        state    <= MRT_IDLE;
        gathered <= '0;
        attempts <= '0;
      end else if (busy) begin
        gathered <= (sum_i > TOKENS) ? CNT_W'(TOKENS) : CNT_W'(sum_i);
        if (retry_ev) begin
          attempts <= attempts + 1'b1;
        end
        if (escalate_ev) begin
          state <= MRT_PERSIST;
        end
      end
    end
  end

  assign req_issue     = req_q;
  assign persist_issue = per_q;
  assign miss_done     = sat_ev;

endmodule

// File: rtl/mrt_checker.sv
module mrt_checker #(
  parameter int RETRY_LIMIT = 4
) (
  input logic clk,
  input logic rst_n,
  input logic miss_start,
  input logic busy,
  input logic req_issue,
  input logic persist_issue,
  input logic miss_done
);
  logic [7:0] issue_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) issue_cnt <= '0;
    else if (miss_done) issue_cnt <= '0;
    else if (req_issue) issue_cnt <= issue_cnt + 8'd1;
  end

  assert_start_issues_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && miss_start) |=> (busy && req_issue));

  assert_done_in_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_done |-> busy);

  assert_done_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_done |=> !busy);

  assert_retry_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(issue_cnt) <= RETRY_LIMIT);

  assert_escalate_after_R5: assert property (@(posedge clk) disable iff (!rst_n)
    persist_issue |-> (int'(issue_cnt) == RETRY_LIMIT));

  assert_issue_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_issue && persist_issue));

  assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(req_issue || persist_issue || miss_done));
endmodule

bind miss_reissue_ctrl mrt_checker #(.RETRY_LIMIT(RETRY_LIMIT)) u_mrt_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_start    (miss_start),
  .busy          (busy),
  .req_issue     (req_issue),
  .persist_issue (persist_issue),
  .miss_done     (miss_done)
);

// File: tb/test_miss_reissue_ctrl.sv
module test_miss_reissue_ctrl;
  localparam int T    = 4;
  localparam int TW   = 8;
  localparam int CAP  = 255;
  localparam int IAVG = 3;
  localparam int MINT = 8;
  localparam int RL   = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       miss_start = 1'b0;
  logic       miss_write = 1'b0;
  logic [2:0] tok_in = '0;
  logic       req_issue, persist_issue, miss_done, busy;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // Reference state.
  bit m_busy, m_wr, m_pers, m_req, m_per;
  int m_got, m_timer, m_lat, m_att, m_avg;
  int last_pulse, last_gap, per_seen, req_seen;

  always #2 clk = ~clk;

  miss_reissue_ctrl #(
    .TOKENS(T), .TIMER_W(TW), .RETRY_LIMIT(RL), .PERSIST_SHIFT(3),
    .AVG_SHIFT(3), .INIT_AVG(IAVG), .MIN_TIMEOUT(MINT)
  ) i_miss_reissue_ctrl (
    .clk(clk), .rst_n(rst_n), .miss_start(miss_start), .miss_write(miss_write),
    .tok_in(tok_in), .req_issue(req_issue), .persist_issue(persist_issue),
    .miss_done(miss_done), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int model_limit(input int avg, input bit pers);
    int v;
    v = pers ? avg * 8 : avg * 2;
    if (v < MINT) v = MINT;
    if (v > CAP) v = CAP;
    return v;
  endfunction

  function automatic int model_ema(input int avg, input int s);
    int d;
    d = s - avg;
    if (d >= 0) return avg + d / 8;
    return avg - ((-d + 7) / 8);
  endfunction

  // One cycle: inputs already driven; compare, then advance the reference.
  task automatic step(input bit st, input bit wr, input int tok);
    int sum, lim;
    bit sat, exp_ev;
    miss_start = st; miss_write = wr; tok_in = 3'(tok);
    #1;
    sum = m_got + tok;
    sat = m_busy && (m_wr ? (sum >= T) : (sum >= 1));
    lim = model_limit(m_avg, m_pers);
    exp_ev = m_busy && !sat && (m_timer >= lim);
    check(busy == m_busy, "R2 busy", busy, m_busy);
    check(req_issue == m_req, "R4 req_issue", req_issue, m_req);
    check(persist_issue == m_per, "R5 persist_issue", persist_issue, m_per);
    check(miss_done == sat, "R3 miss_done", miss_done, sat);
    if (req_issue || persist_issue) begin
      last_gap = cyc - last_pulse;
      last_pulse = cyc;
    end
    if (req_issue) req_seen++;
    if (persist_issue) per_seen++;
    @(posedge clk);
    m_req = (!m_busy && st) || (exp_ev && !m_pers && m_att < RL);
    m_per = exp_ev && (m_pers || m_att >= RL);
    if (!m_busy) begin
      if (st) begin
        m_busy = 1; m_wr = wr; m_got = 0; m_timer = 0; m_lat = 0; m_att = 1; m_pers = 0;
      end
    end else if (sat) begin
      m_busy = 0; m_avg = model_ema(m_avg, m_lat); m_got = 0;
    end else begin
      m_got = (sum > T) ? T : sum;
      m_lat = (m_lat < CAP) ? m_lat + 1 : CAP;
      if (exp_ev) begin
        m_timer = 0;
        if (!m_pers && m_att < RL) m_att++;
        else m_pers = 1;
      end else begin
        m_timer = (m_timer < CAP) ? m_timer + 1 : CAP;
      end
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0);
  endtask

  initial begin
    int lim;
    m_busy = 0; m_wr = 0; m_pers = 0; m_req = 0; m_per = 0;
    m_got = 0; m_timer = 0; m_lat = 0; m_att = 0; m_avg = IAVG;
    last_pulse = 0; last_gap = 0; per_seen = 0; req_seen = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy == 0 && req_issue == 0 && persist_issue == 0 && miss_done == 0,
          "R1 reset outputs", {busy, req_issue, persist_issue, miss_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle(2);

    // R2/R3: read miss, one token after three cycles
    step(1, 0, 0);
    check(busy == 1 && req_issue == 1, "R2 first issue", {busy, req_issue}, 3);
    idle(2);
    step(0, 0, 1);
    idle(2);

    // R3: write miss, tokens arriving in pieces
    step(1, 1, 0);
    step(0, 0, 1);
    step(0, 0, 1);
    check(miss_done == 0, "R3 write partial", miss_done, 0);
    step(0, 0, 2);
    idle(2);

    // R4/R5/R6: write with no tokens walks through retries into persistent mode
    req_seen = 0; per_seen = 0;
    step(1, 1, 0);
    lim = model_limit(m_avg, 0);
    while (m_att < RL || m_req) step(0, 0, 0);
    idle(1);
    check(last_gap == lim + 1, "R4 retry spacing", last_gap, lim + 1);
    while (per_seen < 1) step(0, 0, 0);
    check(req_seen == RL, "R5 normal attempts before escalation", req_seen, RL);
    lim = model_limit(m_avg, 1);
    while (per_seen < 2) step(0, 0, 0);
    check(last_gap == lim + 1, "R5 persistent spacing", last_gap, lim + 1);
    check(req_seen == RL, "R6 no normal issue in persistent mode", req_seen, RL);
    step(0, 0, 4);
    idle(2);

    // R7: the average moved; the next retry gap follows the new average
    step(1, 1, 0);
    lim = model_limit(m_avg, 0);
    while (!(req_issue && cyc > last_pulse)) step(0, 0, 0);
    check(last_gap == lim + 1, "R7 gap after average update", last_gap, lim + 1);
    step(0, 0, 4);
    idle(1);

    // R8: start while busy and tokens while idle are ignored
    step(0, 0, 3);
    step(1, 0, 0);
    step(1, 1, 0);
    check(req_issue == 0 && busy == 1, "R8 start while busy", req_issue, 0);
    check(miss_done == 0, "R8 idle tokens not kept", miss_done, 0);
    step(0, 0, 1);
    idle(2);

    // R10: satisfying tokens in the expiry cycle win
    step(1, 0, 0);
    while (m_timer < model_limit(m_avg, 0)) step(0, 0, 0);
    step(0, 0, 1);
    check(req_issue == 0 && persist_issue == 0, "R10 no issue after late completion",
          {req_issue, persist_issue}, 0);
    idle(2);

    // R9: a long stall saturates latency, lifting the persistent limit to the cap
    step(1, 1, 0);
    for (int i = 0; i < 400; i++) step(0, 0, 0);
    check(busy == 1, "R9 stall still tracked", busy, 1);
    step(0, 0, 4);
    idle(1);
    per_seen = 0;
    step(1, 1, 0);
    while (per_seen < 2) step(0, 0, 0);
    check(last_gap == CAP + 1, "R9 capped persistent window", last_gap, CAP + 1);
    step(0, 0, 4);
    idle(3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule